// File: doc/BRIEF.md
# Memory-Type Attribute Register File

This block holds the registers that describe memory caching attributes for a processor core: eight variable ranges, each a base/mask pair, one fixed-range register for the 64 KB granules, two for the 16 KB granules, eight for the 4 KB granules, a page-attribute table register and a default-type register. All registers are 64 bits wide and reset to zero.

A single request port carries indexed reads and writes. Every request gets one registered response in the following cycle. A write is checked against the legality rules of its register class. The response reports whether the write was accepted, and a rejected write leaves the target register unchanged. A read of a mapped index returns the stored value. An unmapped index is refused for both reads and writes. Working out the memory type of an address is left to other logic.

Top module: `mtrr_regfile`

## Requirements
- R1: After reset every mapped register reads back as zero.
- R2: A read of a mapped index returns the stored value with rsp_ok_o=1. A read of an unmapped index (29 to 31) returns rsp_ok_o=0 and rsp_rdata_o=0.
- R3: An accepted write stores the full 64-bit value and responds with rsp_ok_o=1. A rejected write responds with rsp_ok_o=0 and leaves the register unchanged. The write response carries rsp_rdata_o=0.
- R4: The legal range memory-type byte values are 0 (uncached), 1 (write-combining), 4 (write-through), 5 (write-protect) and 6 (write-back). Every other byte value is illegal.
- R5: A write to a fixed-range register (indices 16 to 26) is accepted only if all eight bytes hold legal range types.
- R6: A write to the page-attribute register (index 27) is accepted only if every byte is a legal range type or 7 (weak uncached).
- R7: A write to a variable base (even index 0 to 14) is accepted only if bits 63:36 are zero and the 12-bit field in bits 11:0 equals a legal range type.
- R8: A write to a variable mask (odd index 1 to 15) is accepted only if bits 63:36 are zero and bits 10:0 are zero.
- R9: A write to the default-type register (index 28) is accepted only if bits 7:0 hold a legal range type, bits 63:32 are zero, and the bits under mask 0xFFFF_F300 are zero.
- R10: The index map is as follows. Base n is at 2n and mask n is at 2n+1. Index 16 is the 64K register, 17 and 18 are the 16K registers, and 19 to 26 are the 4K registers covering successive 32 KB regions from 0xC0000. Index 27 is the page-attribute register and index 28 is the default-type register. A write to an unmapped index is rejected.
- R11: rsp_valid_o is high in exactly the cycle after each cycle with req_valid_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 5 | Register index |
| req_wdata_i | input | 64 | Write value |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_ok_o | output | 1 | Read hit or write accepted |
| rsp_rdata_o | output | 64 | Read value, zero otherwise |

## Verification
The assertions assume that req_write_i, req_idx_i and req_wdata_i are known whenever req_valid_i is high, and that nothing else is assumed about them. Any index and any value may arrive in any cycle. The stimulus keeps inputs defined at all times and drives them on the falling edge. Random data is built byte by byte from a mix of legal and illegal types, with occasional high address bits or reserved bits set, so that both accept and reject paths are reached for every register class.

// File: rtl/mtrr_pkg.sv
package mtrr_pkg;
  typedef enum logic [2:0] {
    K_VBASE, K_VMASK, K_FIXED, K_PAT, K_DEF, K_NONE
  } reg_kind_e;

  function automatic logic range_type_ok(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  function automatic logic pat_type_ok(input logic [7:0] t);
    return range_type_ok(t) || (t == 8'd7);
  endfunction
endpackage

// File: rtl/mtrr_lane_check.sv
module mtrr_lane_check #(
  parameter int LANES         = 8,
  parameter bit ALLOW_WEAK_UC = 1'b0
) (
  input  logic [8*LANES-1:0] data_i,
  output logic               ok_o
);
  import mtrr_pkg::*;
  logic [LANES-1:0] lane_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (ALLOW_WEAK_UC) begin : g_pat
      assign lane_ok[g] = pat_type_ok(data_i[8*g +: 8]);
    end else begin : g_rng
      assign lane_ok[g] = range_type_ok(data_i[8*g +: 8]);
    end
  end

  assign ok_o = &lane_ok;
endmodule

// File: rtl/mtrr_idx_decode.sv
module mtrr_idx_decode #(
  parameter int NUM_VAR    = 8,
  parameter int NUM_FIX16K = 2,
  parameter int NUM_FIX4K  = 8,
  parameter int IDX_W      = 5
) (
  input  logic [IDX_W-1:0]     idx_i,
  output mtrr_pkg::reg_kind_e  kind_o,
  output logic                 hit_o
);
  import mtrr_pkg::*;
  localparam int FIX64_IDX = 2 * NUM_VAR;
  localparam int PAT_IDX   = FIX64_IDX + 1 + NUM_FIX16K + NUM_FIX4K;
  localparam int DEF_IDX   = PAT_IDX + 1;

  always_comb begin
    int i;
    i = int'(idx_i);
    if (i < FIX64_IDX)    kind_o = idx_i[0] ? K_VMASK : K_VBASE;
    else if (i < PAT_IDX) kind_o = K_FIXED;
    else if (i == PAT_IDX) kind_o = K_PAT;
    else if (i == DEF_IDX) kind_o = K_DEF;
    else                  kind_o = K_NONE;
  end

  assign hit_o = (kind_o != K_NONE);
endmodule

// File: rtl/mtrr_wr_check.sv
module mtrr_wr_check #(
  parameter int PHYS_W = 36
) (
  input  mtrr_pkg::reg_kind_e kind_i,
  input  logic [63:0]         data_i,
  output logic                ok_o
);
  import mtrr_pkg::*;
  logic fixed_ok, pat_ok, addr_ok, base_ok, mask_ok, def_ok;

  mtrr_lane_check #(.LANES(8), .ALLOW_WEAK_UC(1'b0)) u_fixed_lanes (
    .data_i(data_i), .ok_o(fixed_ok)
  );
  mtrr_lane_check #(.LANES(8), .ALLOW_WEAK_UC(1'b1)) u_pat_lanes (
    .data_i(data_i), .ok_o(pat_ok)
  );

  assign addr_ok = (data_i[63:PHYS_W] == '0);
  // the whole 12-bit field must equal a legal type, so 11:8 must be zero
  assign base_ok = addr_ok && (data_i[11:8] == 4'h0) && range_type_ok(data_i[7:0]);
  assign mask_ok = addr_ok && (data_i[10:0] == 11'h0);
  assign def_ok  = range_type_ok(data_i[7:0]) && (data_i[63:32] == 32'h0)
                   && ((data_i[31:0] & 32'hFFFF_F300) == 32'h0);

  always_comb begin
    unique case (kind_i)
      K_VBASE: ok_o = base_ok;
      K_VMASK: ok_o = mask_ok;
      K_FIXED: ok_o = fixed_ok;
      K_PAT:   ok_o = pat_ok;
      K_DEF:   ok_o = def_ok;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mtrr_store.sv
module mtrr_store #(
  parameter int NUM_REGS = 29,
  parameter int IDX_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [63:0]      wdata_i,
  output logic [63:0]      rdata_o
);
  logic [63:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (we_i && (int'(idx_i) == g))      regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(idx_i) == i) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/mtrr_regfile.sv
module mtrr_regfile #(
  parameter int NUM_VAR    = 8,
  parameter int NUM_FIX16K = 2,
  parameter int NUM_FIX4K  = 8,
  parameter int PHYS_W     = 36,
  parameter int IDX_W      = $clog2(2*NUM_VAR + 1 + NUM_FIX16K + NUM_FIX4K + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [63:0]      req_wdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_ok_o,
  output logic [63:0]      rsp_rdata_o
);
  import mtrr_pkg::*;
  localparam int NUM_REGS = 2*NUM_VAR + 1 + NUM_FIX16K + NUM_FIX4K + 2;

  reg_kind_e   kind;
  logic        hit, wr_ok, we;
  logic [63:0] rd_val;

  mtrr_idx_decode #(
    .NUM_VAR(NUM_VAR), .NUM_FIX16K(NUM_FIX16K), .NUM_FIX4K(NUM_FIX4K), .IDX_W(IDX_W)
  ) u_decode (
    .idx_i(req_idx_i), .kind_o(kind), .hit_o(hit)
  );

  mtrr_wr_check #(.PHYS_W(PHYS_W)) u_check (
    .kind_i(kind), .data_i(req_wdata_i), .ok_o(wr_ok)
  );

  assign we = req_valid_i && req_write_i && hit && wr_ok;

  mtrr_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .idx_i(req_idx_i),
    .wdata_i(req_wdata_i), .rdata_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_ok_o    <= req_write_i ? (hit && wr_ok) : hit;
        rsp_rdata_o <= (!req_write_i && hit) ? rd_val : '0;
      end else begin
        rsp_ok_o    <= 1'b0;
        rsp_rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/mtrr_regfile_chk.sv
module mtrr_regfile_chk #(
  parameter int NUM_VAR    = 8,
  parameter int NUM_FIX16K = 2,
  parameter int NUM_FIX4K  = 8,
  parameter int PHYS_W     = 36,
  parameter int IDX_W      = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [IDX_W-1:0] req_idx_i,
  input logic [63:0]      req_wdata_i,
  input logic             rsp_valid_o,
  input logic             rsp_ok_o,
  input logic [63:0]      rsp_rdata_o
);
  localparam int FIX64_IDX = 2 * NUM_VAR;
  localparam int PAT_IDX   = FIX64_IDX + 1 + NUM_FIX16K + NUM_FIX4K;
  localparam int DEF_IDX   = PAT_IDX + 1;

  logic wr, rd, unmapped;
  assign wr       = req_valid_i && req_write_i;
  assign rd       = req_valid_i && !req_write_i;
  assign unmapped = int'(req_idx_i) > DEF_IDX;

  a_r11_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r11_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r2_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && unmapped) |=> (!rsp_ok_o && rsp_rdata_o == 64'h0));
  a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && unmapped) |=> !rsp_ok_o);
  a_r3_write_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (rsp_rdata_o == 64'h0));
  a_r8_mask_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(req_idx_i) < FIX64_IDX && req_idx_i[0] && (|req_wdata_i[10:0]))
    |=> !rsp_ok_o);
  a_r7_base_high_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(req_idx_i) < FIX64_IDX && !req_idx_i[0] && (|req_wdata_i[63:PHYS_W]))
    |=> !rsp_ok_o);
  a_r9_def_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(req_idx_i) == DEF_IDX && (|req_wdata_i[63:32])) |=> !rsp_ok_o);
  a_r6_pat_all_weak_uc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(req_idx_i) == PAT_IDX && req_wdata_i == 64'h0707_0707_0707_0707)
    |=> rsp_ok_o);
  a_r5_fixed_rejects_seven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && int'(req_idx_i) >= FIX64_IDX && int'(req_idx_i) < PAT_IDX
     && req_wdata_i[7:0] == 8'h07) |=> !rsp_ok_o);
endmodule

bind mtrr_regfile mtrr_regfile_chk #(
  .NUM_VAR(NUM_VAR), .NUM_FIX16K(NUM_FIX16K), .NUM_FIX4K(NUM_FIX4K),
  .PHYS_W(PHYS_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_idx_i(req_idx_i), .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
  .rsp_ok_o(rsp_ok_o), .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/mtrr_regfile_tb.sv
module mtrr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_ok;
  logic [63:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] model [32];

  always #10 clk = ~clk;

  mtrr_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_idx_i(req_idx), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_ok_o(rsp_ok), .rsp_rdata_o(rsp_rdata)
  );

  function automatic bit rng_ok(input logic [7:0] t);
    return t == 0 || t == 1 || t == 4 || t == 5 || t == 6;
  endfunction

  function automatic bit all_bytes(input logic [63:0] d, input bit pat);
    for (int b = 0; b < 8; b++)
      if (!(rng_ok(d[8*b +: 8]) || (pat && d[8*b +: 8] == 8'd7))) return 0;
    return 1;
  endfunction

  // R4..R10 expected acceptance
  function automatic bit exp_accept(input int idx, input logic [63:0] d);
    if (idx < 16 && idx % 2 == 0) return d[63:36] == 0 && d[11:8] == 0 && rng_ok(d[7:0]);
    if (idx < 16) return d[63:36] == 0 && d[10:0] == 0;
    if (idx <= 26) return all_bytes(d, 0);
    if (idx == 27) return all_bytes(d, 1);
    if (idx == 28) return rng_ok(d[7:0]) && d[63:32] == 0 && (d[31:0] & 32'hFFFF_F300) == 0;
    return 0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int idx, input logic [63:0] d, input string req);
    bit ok_e;
    logic [63:0] rd_e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_idx = idx[4:0]; req_wdata = d;
    if (wr) begin
      ok_e = exp_accept(idx, d);
      rd_e = 0;
      if (ok_e) model[idx] = d;
    end else begin
      ok_e = idx <= 28;
      rd_e = ok_e ? model[idx] : 64'h0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R11 valid"}, {63'h0, rsp_valid}, 64'h1);
    check({req, " ok"}, {63'h0, rsp_ok}, {63'h0, ok_e});
    check({req, " rdata"}, rsp_rdata, rd_e);
  endtask

  function automatic logic [7:0] rand_type(input bit pat);
    int r;
    logic [7:0] legal [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
    r = $urandom_range(0, 15);
    if (r < 12) return legal[$urandom_range(0, 4)];
    if (r < 14 && pat) return 8'd7;
    return 8'($urandom_range(0, 255));
  endfunction

  function automatic logic [63:0] rand_data(input int idx);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) d[8*b +: 8] = rand_type(idx == 27);
    if (idx < 16 || idx == 28) begin
      d = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) != 0) d[63:36] = 0;
      if (idx == 28 && $urandom_range(0, 3) != 0) d = {32'h0, 20'h0, d[11:10], 2'b0, rand_type(0)};
      else if (idx < 16 && idx % 2 == 0 && $urandom_range(0, 3) != 0) d[11:0] = {4'h0, rand_type(0)};
      else if (idx < 16 && idx % 2 == 1 && $urandom_range(0, 3) != 0) d[10:0] = 0;
    end
    return d;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid at reset", {63'h0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) access(0, i, 0, "R1/R2 reset read");
    // directed corners
    access(1, 27, 64'h0707_0707_0707_0707, "R6 pat weak uc");
    access(0, 27, 0, "R6 readback");
    access(1, 16, 64'h0606_0605_0504_0107, "R5 fixed byte 7");
    access(1, 16, 64'h0606_0605_0504_0100, "R5 fixed legal");
    access(1, 20, 64'h0203_0404_0404_0404, "R4 illegal 2/3");
    access(0, 20, 0, "R3 unchanged");
    access(1, 0, 64'h0000_000F_FFFF_F006, "R7 base legal");
    access(1, 0, 64'h0000_0010_0000_0006, "R7 base high addr");
    access(1, 2, 64'h0000_0000_0000_0106, "R7 base bit8");
    access(1, 1, 64'h0000_000F_FFFF_F800, "R8 mask legal");
    access(1, 1, 64'h0000_000F_FFFF_F801, "R8 mask bit0");
    access(1, 3, 64'h0000_0000_0000_0400, "R8 mask bit10");
    access(1, 28, 64'h0000_0000_0000_0C06, "R9 def legal");
    access(1, 28, 64'h0000_0001_0000_0006, "R9 def upper");
    access(1, 28, 64'h0000_0000_0000_0106, "R9 def reserved");
    access(1, 29, 64'h0, "R10 unmapped write");
    access(0, 31, 0, "R2 unmapped read");
    for (int i = 0; i < 29; i++) access(0, i, 0, "R10 map readback");
    for (int n = 0; n < 400; n++) begin
      int idx;
      idx = $urandom_range(0, 31);
      if ($urandom_range(0, 2) == 0) access(0, idx, 0, "R2 random read");
      else access(1, idx, rand_data(idx), "R3 random write");
    end
    for (int i = 0; i < 29; i++) access(0, i, 0, "R3 final readback");
    @(negedge clk);
    check("R11 idle", {63'h0, rsp_valid}, 64'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule